// File: doc/BRIEF.md
# Reset Release Synchronizer

This block turns a raw, asynchronous, active-low reset request into an active-high reset that is safe to drive the asynchronous reset pins of every register in one clock domain. The conditioned reset rises at once when the request arrives, with no clock edge involved. It falls only on a rising edge of the domain clock, so every register in the domain leaves reset on the same cycle.

The block is a shift chain of flops. The raw reset forces every flop to one through its asynchronous preset. The first flop's data input is tied to zero. Once the request is withdrawn, zeros march down the chain one stage per rising edge. The last stage drives the conditioned reset. The chain length is a parameter that trades release latency against the time the first stages get to settle.

Top module: `rst_release_sync`

## Requirements
- R1: While `arst_n` is held low and the clock runs, `rst_out` is 1 and stays 1.
- R2: When `arst_n` falls, `rst_out` becomes 1 within the same clock phase. No rising clock edge is needed, and it also happens while the clock is stopped.
- R3: After `arst_n` rises between clock edges, `rst_out` stays 1 through the first STAGES-1 rising edges. It becomes 0 right after rising edge number STAGES.
- R4: Once `rst_out` is 0, it stays 0 on every later cycle for as long as `arst_n` stays high.
- R5: `rst_out` changes only just after a rising clock edge while `arst_n` is high. Sampled at the falling clock edge, it equals the value it had just after the preceding rising edge.
- R6: If `arst_n` falls again partway through a release, every stage returns to 1 immediately and `rst_out` is 1. The next release again takes the full STAGES rising edges.
- R7: A STAGES value below 2 is raised to 2. Such an instance releases after exactly 2 rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Destination domain clock |
| arst_n | input | 1 | Raw reset request, active low, asynchronous to `clk` |
| rst_out | output | 1 | Conditioned reset, active high, asserted asynchronously and released on a rising edge of `clk` |

## Verification
The bench builds three copies side by side, all sharing one clock and one reset request:
- STAGES=2, the default and the shortest legal chain.
- STAGES=1, which must be raised to two.
- STAGES=4, which has enough stages to interrupt a release at several depths.

Having three lengths lets one release sequence confirm that the latency equals the chain length, rather than a fixed count. The four-stage copy makes it possible to re-apply reset after one and after two zeros have entered and then prove that the following release restarts from a full chain. The clock can be frozen in the bench, which shows the assert path working with no edge at all.

// File: rtl/rst_sync_pkg.sv
package rst_sync_pkg;

  // Shortest chain that gives the first stage a full cycle to settle.
  localparam int unsigned MIN_STAGES = 2;

  // Value shifted into the head of the chain once the request is withdrawn.
  localparam logic RELEASE_LEVEL = 1'b0;

  // Value every stage is forced to while the request is active.
  localparam logic HOLD_LEVEL = 1'b1;

  function automatic int unsigned eff_stages(input int unsigned requested);
    return (requested < MIN_STAGES) ? MIN_STAGES : requested;
  endfunction

endpackage

// File: rtl/preset_flop.sv
module preset_flop (
  input  logic clk,
  input  logic set_n,
  input  logic en,
  input  logic d,
  output logic q
);
  import rst_sync_pkg::*;

  logic q_nxt;

  // Next-state process: hold unless enabled.
  always_comb begin
    q_nxt = q;
    if (en) begin
      q_nxt = d;
    end
  end

  // Register process: asynchronous preset to the hold level.
  always_ff @(posedge clk or negedge set_n) begin
    if (!set_n) begin
      q <= HOLD_LEVEL;
    end else begin
      q <= q_nxt;
    end
  end

endmodule

// File: rtl/release_chain.sv
module release_chain #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned DEPTH = rst_sync_pkg::eff_stages(STAGES)
) (
  input  logic             clk,
  input  logic             set_n,
  output logic [DEPTH-1:0] q
);
  import rst_sync_pkg::*;

  logic [DEPTH-1:0] d_vec;

  // Head takes the release level; each later stage takes its predecessor.
  always_comb begin
    d_vec[0] = RELEASE_LEVEL;
    for (int i = 1; i < DEPTH; i++) begin
      d_vec[i] = q[i-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    preset_flop u_ff (
      .clk   (clk),
      .set_n (set_n),
      .en    (1'b1),
      .d     (d_vec[g]),
      .q     (q[g])
    );
  end

endmodule

// File: rtl/rst_release_sync.sv
module rst_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_out
);
  localparam int unsigned DEPTH = rst_sync_pkg::eff_stages(STAGES);

  logic [DEPTH-1:0] stage_q;

  release_chain #(
    .STAGES (STAGES)
  ) u_chain (
    .clk   (clk),
    .set_n (arst_n),
    .q     (stage_q)
  );

  assign rst_out = stage_q[DEPTH-1];

endmodule

// File: rtl/rst_release_sync_chk.sv
module rst_release_sync_chk #(
  parameter int unsigned STAGES = 2,
  localparam int unsigned DEPTH = rst_sync_pkg::eff_stages(STAGES),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             arst_n,
  input logic             rst_out,
  input logic [DEPTH-1:0] chain
);

  // Rising edges seen since the last release, saturating at DEPTH.
  logic [CW-1:0] edges_seen;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      edges_seen <= '0;
    end else if (edges_seen < CW'(DEPTH)) begin
      edges_seen <= edges_seen + CW'(1);
    end
  end

  // R2 and R1: an active request always shows as an asserted output.
  p_assert_now_r2: assert property (@(negedge clk) disable iff ($isunknown(arst_n))
    !arst_n |-> rst_out);

  // R6: an active request leaves every stage at one.
  p_full_preset_r6: assert property (@(negedge clk) disable iff ($isunknown(arst_n))
    !arst_n |-> (&chain));

  // R3: the output tracks the number of edges since the release.
  p_release_latency_r3: assert property (@(posedge clk) disable iff (!arst_n)
    rst_out == (edges_seen < CW'(DEPTH)));

  // R4: a released output never comes back without a request.
  p_stays_low_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !rst_out |=> !rst_out);

  // R5: the chain holds a contiguous block of ones at its tail end.
  p_thermometer_r5: assert property (@(posedge clk) disable iff (!arst_n)
    (((~chain) + DEPTH'(1)) & (~chain)) == '0);

endmodule

bind rst_release_sync rst_release_sync_chk #(.STAGES(STAGES)) u_chk (
  .clk     (clk),
  .arst_n  (arst_n),
  .rst_out (rst_out),
  .chain   (stage_q)
);

// File: tb/test_rst_release_sync.sv
module test_rst_release_sync;

  localparam int CLK_PERIOD = 10;
  localparam int N_A = 2;  // default instance
  localparam int N_B = 2;  // STAGES=1, raised to two
  localparam int N_C = 4;

  logic clk;
  logic clk_run;
  logic arst_n;
  logic rst_a, rst_b, rst_c;

  int checks;
  int errors;

  rst_release_sync i_rst_release_sync (
    .clk (clk), .arst_n (arst_n), .rst_out (rst_a)
  );

  rst_release_sync #(.STAGES(1)) i_rst_release_sync_s1 (
    .clk (clk), .arst_n (arst_n), .rst_out (rst_b)
  );

  rst_release_sync #(.STAGES(4)) i_rst_release_sync_s4 (
    .clk (clk), .arst_n (arst_n), .rst_out (rst_c)
  );

  initial begin
    clk = 1'b0;
    clk_run = 1'b1;
  end

  always begin
    #(CLK_PERIOD / 2);
    if (clk_run) clk = ~clk;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Releases between edges; checks the edge count of all three chains.
  task automatic release_and_count(input string tag);
    @(negedge clk);
    #1 arst_n = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(posedge clk);
      #1;
      chk("R3", {tag, " len2"}, rst_a, logic'(k < N_A));
      chk("R7", {tag, " len1->2"}, rst_b, logic'(k < N_B));
      chk("R3", {tag, " len4"}, rst_c, logic'(k < N_C));
      @(negedge clk);
      chk("R5", {tag, " len2 mid"}, rst_a, logic'(k < N_A));
      chk("R5", {tag, " len4 mid"}, rst_c, logic'(k < N_C));
    end
  endtask

  task automatic t_reset_state();
    arst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "len2 in reset", rst_a, 1'b1);
    chk("R1", "len1 in reset", rst_b, 1'b1);
    chk("R1", "len4 in reset", rst_c, 1'b1);
  endtask

  task automatic t_hold_low();
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k % 5 == 0) begin
        chk("R4", "len2 held", rst_a, 1'b0);
        chk("R4", "len4 held", rst_c, 1'b0);
      end
    end
  endtask

  task automatic t_async_assert_stopped_clock();
    @(negedge clk);
    clk_run = 1'b0;
    #(CLK_PERIOD * 3);
    arst_n = 1'b0;
    #1;
    chk("R2", "len2 no clock", rst_a, 1'b1);
    chk("R2", "len4 no clock", rst_c, 1'b1);
    #(CLK_PERIOD * 2);
    chk("R2", "len1 no clock", rst_b, 1'b1);
    clk_run = 1'b1;
  endtask

  task automatic t_reassert_midway(input int depth_before);
    @(negedge clk);
    #1 arst_n = 1'b1;
    repeat (depth_before) @(posedge clk);
    #2 arst_n = 1'b0;
    #1;
    chk("R6", "len4 reasserted", rst_c, 1'b1);
    chk("R6", "len2 reasserted", rst_a, 1'b1);
    repeat (2) @(posedge clk);
    release_and_count("R6 after reassert");
  endtask

  initial begin
    checks = 0;
    errors = 0;
    arst_n = 1'b0;
    t_reset_state();
    release_and_count("first release");
    t_hold_low();
    t_async_assert_stopped_clock();
    release_and_count("restart");
    t_reassert_midway(1);
    t_reassert_midway(2);
    t_hold_low();
    summary();
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog all: actual=timeout expected=completion");
    summary();
  end

endmodule